// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

The unit holds a small array of shared words that several requesters reach through their own request ports. Each request names an operation, a word address, a write value and, for compare-and-swap, an expected value. Beyond plain loads and stores, the unit offers test-and-set, swap, compare-and-swap and a load-linked/store-conditional pair. One request is granted per cycle. The granted operation reads and updates its word within that cycle, so no other access can fall between the read and the write.

Requesters use the unit to build locks and lock-free updates. A word holding 0 is a free lock. A test-and-set that returns 0 has acquired the lock, one that returns 1 found it held, and a plain store of 0 frees it. The load-linked/store-conditional pair lets a requester compute any new value. If another port wrote the word in between, the conditional store fails and the requester retries from the load-linked. Results come back on a single shared response channel tagged with the requesting port.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset, no response is valid, no port is granted while no request is valid, and every word reads 0.
- R2: Op code 0 (load) returns the word. Op code 1 (store) writes the write value and returns 0.
- R3: Op code 2 (test-and-set) returns the old word and writes 1. On a free lock word the first test-and-set returns 0, a later one returns 1, and after a store of 0 a test-and-set returns 0 again.
- R4: Op code 3 (swap) writes the write value and returns the old word.
- R5: Op code 4 (compare-and-swap) writes the write value and returns 1 when the word equals the expected value. Otherwise it returns 0 and leaves the word unchanged.
- R6: Op code 5 (load-linked) returns the word and records a reservation of that address for the port. Op code 6 (store-conditional) writes and returns 1 when the port's reservation is valid for that address.
- R7: A store-conditional returns 0 and does not write in three cases: another port wrote the reserved address after the load-linked, the address differs from the reserved one, or no load-linked preceded it since the port's last store-conditional. Every store-conditional clears the port's reservation.
- R8: A reservation survives writes by other ports to other addresses and writes by its own port.
- R9: At most one port is ready in a cycle, only a port with a valid request is ready, and simultaneous requests are granted round-robin starting after the last granted port.
- R10: A response is valid in the cycle after each accepted request. It carries the requesting port number and the result, so each port's responses come back in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | N_PORTS | Request valid per port |
| req_ready_o | output | N_PORTS | Grant per port; a request is accepted when valid and ready |
| req_op_i | input | N_PORTS x 3 | Operation code per port |
| req_addr_i | input | N_PORTS x ADDR_W | Word address per port |
| req_wdata_i | input | N_PORTS x DATA_W | Write / new value per port |
| req_cmp_i | input | N_PORTS x DATA_W | Expected value for compare-and-swap |
| resp_valid_o | output | 1 | Response valid |
| resp_port_o | output | $clog2(N_PORTS) | Port that issued the answered request |
| resp_data_o | output | DATA_W | Old word, or a 1/0 success flag |

## Verification
Ready is a combinational function of the valid inputs and the round-robin pointer. The bench therefore reads it a short delay after driving inputs on the falling edge. The memory update and the registered response both take effect at the rising edge that accepts a request, so every result is due exactly one cycle after acceptance. The bench samples it at the next falling edge and drops the request there before another edge can re-issue it. A test that follows reads memory back with a fresh load and reads the result one cycle after that load.

// File: rtl/amu_pkg.sv
package amu_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_TAS   = 3'd2,
    OP_SWAP  = 3'd3,
    OP_CAS   = 3'd4,
    OP_LL    = 3'd5,
    OP_SC    = 3'd6
  } amu_op_e;
endpackage

// File: rtl/amu_rr_arb.sv
module amu_rr_arb #(
  parameter int N_PORTS = 3,
  localparam int IDX_W = $clog2(N_PORTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] req_i,
  output logic [N_PORTS-1:0] gnt_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int k = 0; k < N_PORTS; k++) begin
      automatic int c = (int'(ptr_q) + k) % N_PORTS;
      if (!any_o && req_i[c]) begin
        any_o    = 1'b1;
        gnt_o[c] = 1'b1;
        idx_o    = IDX_W'(c);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (any_o) ptr_q <= (int'(idx_o) == N_PORTS - 1) ? '0 : idx_o + 1'b1;
  end
endmodule

// File: rtl/amu_resv.sv
module amu_resv #(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 4,
  localparam int IDX_W = $clog2(N_PORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  amu_pkg::amu_op_e  op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output logic              hit_o
);
  logic [N_PORTS-1:0]             vld_q;
  logic [N_PORTS-1:0][ADDR_W-1:0] addr_q;

  assign hit_o = vld_q[idx_i] && (addr_q[idx_i] == addr_i);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_slot
    logic own;
    assign own = (int'(idx_i) == p);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[p]  <= 1'b0;
        addr_q[p] <= '0;
      end else if (fire_i) begin
        if (own && op_i == amu_pkg::OP_LL) begin
          vld_q[p]  <= 1'b1;
          addr_q[p] <= addr_i;
        end else if (own && op_i == amu_pkg::OP_SC) begin
          vld_q[p] <= 1'b0;
        end else if (!own && wr_en_i && addr_q[p] == addr_i) begin
          vld_q[p] <= 1'b0;  // foreign write breaks the link
        end
      end
    end
  end
endmodule

// File: rtl/amu_core.sv
module amu_core #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  amu_pkg::amu_op_e  op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cmp_i,
  input  logic              resv_hit_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] result_o
);
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] old, wval;
  logic              wr;

  assign old = mem_q[addr_i];

  always_comb begin
    wr       = 1'b0;
    wval     = wdata_i;
    result_o = old;
    unique case (op_i)
      amu_pkg::OP_STORE: begin wr = 1'b1; result_o = '0; end
      amu_pkg::OP_TAS:   begin wr = 1'b1; wval = DATA_W'(1); end
      amu_pkg::OP_SWAP:  wr = 1'b1;
      amu_pkg::OP_CAS: begin
        wr       = (old == cmp_i);
        result_o = DATA_W'(old == cmp_i);
      end
      amu_pkg::OP_SC: begin
        wr       = resv_hit_i;
        result_o = DATA_W'(resv_hit_i);
      end
      default: ;
    endcase
  end

  assign wr_en_o = fire_i && wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (wr_en_o) mem_q[addr_i] <= wval;
  end
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit #(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  localparam int IDX_W = $clog2(N_PORTS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_PORTS-1:0]             req_valid_i,
  output logic [N_PORTS-1:0]             req_ready_o,
  input  logic [N_PORTS-1:0][2:0]        req_op_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] req_addr_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] req_wdata_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] req_cmp_i,
  output logic                           resp_valid_o,
  output logic [IDX_W-1:0]               resp_port_o,
  output logic [DATA_W-1:0]              resp_data_o
);
  logic             fire, wr_en, hit;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] result;
  amu_pkg::amu_op_e op;

  amu_rr_arb #(.N_PORTS(N_PORTS)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_valid_i),
    .gnt_o(req_ready_o), .idx_o(idx), .any_o(fire)
  );

  assign op = amu_pkg::amu_op_e'(req_op_i[idx]);

  amu_resv #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) u_resv (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .idx_i(idx),
    .op_i(op), .addr_i(req_addr_i[idx]), .wr_en_i(wr_en), .hit_o(hit)
  );

  amu_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .op_i(op),
    .addr_i(req_addr_i[idx]), .wdata_i(req_wdata_i[idx]),
    .cmp_i(req_cmp_i[idx]), .resv_hit_i(hit),
    .wr_en_o(wr_en), .result_o(result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_port_o  <= '0;
      resp_data_o  <= '0;
    end else begin
      resp_valid_o <= fire;
      if (fire) begin
        resp_port_o <= idx;
        resp_data_o <= result;
      end
    end
  end
endmodule

// File: rtl/amu_checker.sv
module amu_checker #(
  parameter int N_PORTS = 3,
  parameter int DATA_W  = 16,
  localparam int IDX_W = $clog2(N_PORTS)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_PORTS-1:0]      req_valid_i,
  input logic [N_PORTS-1:0]      req_ready_o,
  input logic [N_PORTS-1:0][2:0] req_op_i,
  input logic                    resp_valid_o,
  input logic [IDX_W-1:0]        resp_port_o,
  input logic [DATA_W-1:0]       resp_data_o
);
  logic             acc;
  logic [IDX_W-1:0] gidx;
  logic [2:0]       gop;

  always_comb begin
    gidx = '0;
    gop  = '0;
    for (int p = 0; p < N_PORTS; p++)
      if (req_ready_o[p]) begin gidx = IDX_W'(p); gop = req_op_i[p]; end
  end
  assign acc = |(req_valid_i & req_ready_o);

  p_one_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));
  p_grant_needs_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == '0);
  p_resp_due_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> resp_valid_o);
  p_no_spurious_resp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !resp_valid_o);
  p_resp_port_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> resp_port_o == $past(gidx));
  p_flag_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (gop == 3'd4 || gop == 3'd6)) |=> resp_data_o <= DATA_W'(1));
endmodule

bind atomic_mem_unit amu_checker #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .req_op_i(req_op_i), .resp_valid_o(resp_valid_o),
  .resp_port_o(resp_port_o), .resp_data_o(resp_data_o)
);

// File: tb/tb_atomic_mem_unit.sv
module tb_atomic_mem_unit;
  localparam int NP = 3, AW = 4, DW = 16, IW = $clog2(NP);

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] vld = '0, rdy;
  logic [NP-1:0][2:0] op = '0;
  logic [NP-1:0][AW-1:0] addr = '0;
  logic [NP-1:0][DW-1:0] wd = '0, cmp = '0;
  logic rv;
  logic [IW-1:0] rp;
  logic [DW-1:0] rdat;
  int checks = 0, fails = 0, rr_next = 0;

  always #2 clk = ~clk;

  atomic_mem_unit #(.N_PORTS(NP), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_ready_o(rdy),
    .req_op_i(op), .req_addr_i(addr), .req_wdata_i(wd), .req_cmp_i(cmp),
    .resp_valid_o(rv), .resp_port_o(rp), .resp_data_o(rdat)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one request from port p; result returned one cycle after acceptance
  task automatic issue(int p, amu_pkg::amu_op_e o, int a, int w, int c,
                       string tag, int exp);
    @(negedge clk);
    vld[p] = 1; op[p] = o; addr[p] = AW'(a); wd[p] = DW'(w); cmp[p] = DW'(c);
    #1 check({tag, " ready"}, int'(rdy), 1 << p);
    @(negedge clk);
    vld[p] = 0;
    check({tag, " valid"}, int'(rv), 1);
    check({tag, " port"}, int'(rp), p);
    check({tag, " data"}, int'(rdat), exp);
    rr_next = (p + 1) % NP;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 resp_valid", int'(rv), 0);
    check("R1 ready idle", int'(rdy), 0);
    issue(0, amu_pkg::OP_LOAD, 5, 0, 0, "R1 load zero", 0);
    issue(2, amu_pkg::OP_LOAD, 15, 0, 0, "R1 load zero top", 0);
  endtask

  task automatic t_load_store;
    issue(0, amu_pkg::OP_STORE, 3, 'hBEEF, 0, "R2 store", 0);
    issue(1, amu_pkg::OP_LOAD, 3, 0, 0, "R2 load", 'hBEEF);
  endtask

  task automatic t_tas;
    issue(0, amu_pkg::OP_TAS, 7, 0, 0, "R3 acquire", 0);
    issue(1, amu_pkg::OP_TAS, 7, 0, 0, "R3 held", 1);
    issue(0, amu_pkg::OP_STORE, 7, 0, 0, "R3 release", 0);
    issue(2, amu_pkg::OP_TAS, 7, 0, 0, "R3 reacquire", 0);
    issue(1, amu_pkg::OP_STORE, 8, 'h55, 0, "R3 prep", 0);
    issue(1, amu_pkg::OP_TAS, 8, 0, 0, "R3 old value", 'h55);
    issue(1, amu_pkg::OP_LOAD, 8, 0, 0, "R3 wrote one", 1);
  endtask

  task automatic t_swap;
    issue(1, amu_pkg::OP_SWAP, 3, 'h1234, 0, "R4 swap", 'hBEEF);
    issue(0, amu_pkg::OP_LOAD, 3, 0, 0, "R4 readback", 'h1234);
  endtask

  task automatic t_cas;
    issue(2, amu_pkg::OP_CAS, 3, 'h5555, 'h1234, "R5 cas hit", 1);
    issue(0, amu_pkg::OP_LOAD, 3, 0, 0, "R5 hit wrote", 'h5555);
    issue(2, amu_pkg::OP_CAS, 3, 'h0009, 'h1234, "R5 cas miss", 0);
    issue(0, amu_pkg::OP_LOAD, 3, 0, 0, "R5 miss kept", 'h5555);
  endtask

  task automatic t_llsc;
    issue(0, amu_pkg::OP_LL, 9, 0, 0, "R6 ll", 0);
    issue(0, amu_pkg::OP_SC, 9, 'h42, 0, "R6 sc ok", 1);
    issue(1, amu_pkg::OP_LOAD, 9, 0, 0, "R6 sc wrote", 'h42);
  endtask

  task automatic t_sc_fail;
    issue(0, amu_pkg::OP_LL, 9, 0, 0, "R7 ll", 'h42);
    issue(1, amu_pkg::OP_STORE, 9, 7, 0, "R7 foreign store", 0);
    issue(0, amu_pkg::OP_SC, 9, 'h99, 0, "R7 sc broken", 0);
    issue(2, amu_pkg::OP_LOAD, 9, 0, 0, "R7 no write", 7);
    issue(0, amu_pkg::OP_SC, 9, 'h99, 0, "R7 sc no ll", 0);
    issue(0, amu_pkg::OP_LL, 9, 0, 0, "R7 ll again", 7);
    issue(0, amu_pkg::OP_SC, 10, 'h99, 0, "R7 sc wrong addr", 0);
    issue(0, amu_pkg::OP_SC, 9, 'h99, 0, "R7 cleared by sc", 0);
    issue(2, amu_pkg::OP_LL, 9, 0, 0, "R7 ll p2", 7);
    issue(0, amu_pkg::OP_LL, 9, 0, 0, "R7 ll p0", 7);
    issue(0, amu_pkg::OP_SC, 9, 'h66, 0, "R7 sc p0 wins", 1);
    issue(2, amu_pkg::OP_SC, 9, 'h77, 0, "R7 sc p2 loses", 0);
    issue(1, amu_pkg::OP_LOAD, 9, 0, 0, "R7 winner value", 'h66);
  endtask

  task automatic t_resv_keep;
    issue(0, amu_pkg::OP_LL, 9, 0, 0, "R8 ll", 'h66);
    issue(1, amu_pkg::OP_STORE, 2, 5, 0, "R8 other addr", 0);
    issue(0, amu_pkg::OP_STORE, 9, 'h11, 0, "R8 own store", 0);
    issue(0, amu_pkg::OP_SC, 9, 'h22, 0, "R8 sc survives", 1);
    issue(1, amu_pkg::OP_LOAD, 9, 0, 0, "R8 readback", 'h22);
  endtask

  task automatic t_rr;
    int exp_g = rr_next;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      vld[p] = 1; op[p] = amu_pkg::OP_LOAD; addr[p] = AW'(9);
    end
    for (int k = 0; k < 2 * NP; k++) begin
      #1 check("R9 rotate", int'(rdy), 1 << exp_g);
      @(negedge clk);
      check("R10 resp valid", int'(rv), 1);
      check("R10 resp port", int'(rp), exp_g);
      check("R10 resp data", int'(rdat), 'h22);
      exp_g = (exp_g + 1) % NP;
    end
    vld[1] = 0;  // ports 0 and 2 only
    if (exp_g == 1) exp_g = 2;
    for (int k = 0; k < 4; k++) begin
      #1 check("R9 skip idle", int'(rdy), 1 << exp_g);
      @(negedge clk);
      check("R10 resp port skip", int'(rp), exp_g);
      exp_g = (exp_g == 0) ? 2 : 0;
    end
    vld = '0;
    @(negedge clk);
    check("R10 idle no resp", int'(rv), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_load_store();
    t_tas();
    t_swap();
    t_cas();
    t_llsc();
    t_sc_fail();
    t_resv_keep();
    t_rr();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule